// File: doc/BRIEF.md
# Selectable Interrupt Latch Controller

This block collects the event flags of an ADC sample path that feeds a FIFO. It turns chosen events into sticky status bits and drives one interrupt request line to the host. Six event inputs arrive as levels: FIFO not-empty, FIFO half-full, FIFO full, end of channel scan, end of acquisition and end of burst. A status bit is set on the rising edge of its event and then holds until software clears it.

Software programs the block through a single write port. The written word carries three things: a 2-bit code that picks one of three general interrupt sources, an enable for that general source, and a separate enable for the end-of-acquisition interrupt. It also carries three clear bits. A clear bit acts only in the cycle it is written, so software never has to write it back to zero. A combinational read port returns the latched bits next to the live FIFO flags. The block has no stream interface: every pin is a plain control or status level, and there is no back-pressure.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the source code, both enables and every latch are zero. `rd_data_o` therefore shows 0 in bits 0, 1, 2, 5 and 6, and `irq_o` is low.
- R2: Write-word bits [1:0] select the general source: 2'b11 is FIFO not-empty, 2'b01 is FIFO half-full, 2'b10 is end of channel scan, and 2'b00 is no source. While the general enable is 1, a rising edge of the selected event sets the general latch (read bit 1). Edges on events that are not selected do not set it, and under code 00 nothing sets it.
- R3: Write-word bit 2 is the general enable. While it is 0 the general latch never sets and the general source raises no request.
- R4: A rising edge of `acq_done_i` sets the end-of-acquisition latch (read bit 0) whatever the enable says. Write-word bit 3 is the enable that lets this latch raise the request.
- R5: Writing 1 to write-word bit 4 clears the end-of-acquisition latch and the end-of-burst latch. Writing 1 to bit 5 clears the general latch and the latched not-empty bit. Writing 1 to bit 6 clears the FIFO-full latch. Writing 0 to any of these bits changes nothing.
- R6: If a latch's setting edge and its clear strobe fall in the same cycle, the latch ends up set.
- R7: A clear bit acts only in the cycle it is written. An event edge in any later cycle sets the latch again without another write.
- R8: A rising edge of `burst_done_i` sets the end-of-burst latch (read bit 2) only while `burst_mode_i` is 1.
- R9: A rising edge of `fifo_full_i` sets the FIFO-full latch (read bit 6). The latch stays set after the flag falls, until it is cleared.
- R10: Read bits 3 and 4 show the live FIFO half-full and not-empty inputs in the same cycle. Read bit 5 shows the latched not-empty edge, which is set whatever the source code is.
- R11: `irq_o` is a level equal to (general latch AND general enable) OR (end-of-acquisition latch AND its enable).
- R12: A latch is set only by a rising edge. If the event input stays high across a clear, the latch stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_not_empty_i | input | 1 | Live FIFO not-empty flag |
| fifo_half_full_i | input | 1 | Live FIFO half-full flag |
| fifo_full_i | input | 1 | Live FIFO full flag |
| scan_done_i | input | 1 | End of channel scan event |
| acq_done_i | input | 1 | End of acquisition event |
| burst_done_i | input | 1 | End of burst event |
| burst_mode_i | input | 1 | Burst mode active; gates the end-of-burst latch |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 7 | Control word: [1:0] source, [2] general enable, [3] acquisition enable, [4] acq/burst clear, [5] general/not-empty clear, [6] full clear |
| rd_data_o | output | 7 | Status: [0] acq, [1] general, [2] burst, [3] half live, [4] not-empty live, [5] not-empty latched, [6] full latched |
| irq_o | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a setting edge and a clear strobe landing in the same clock edge. The bench raises `fifo_full_i` and issues the full-clear write in the same half cycle, so both are sampled at one edge. It then reads bit 6 to confirm that the set wins. The rising-edge-only rule is reached by holding `fifo_not_empty_i` high across a general clear. A bit that is still clear afterwards shows that a level does not re-arm the latch.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int WR_W   = 7;
  localparam int RD_W   = 7;
  localparam int NUM_EV = 6;
  localparam int NUM_LT = 5;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_HALF   = 2'b01,
    SRC_SCAN   = 2'b10,
    SRC_NEMPTY = 2'b11
  } src_sel_e;

  // event vector positions
  localparam int EV_NEMPTY = 0;
  localparam int EV_HALF   = 1;
  localparam int EV_SCAN   = 2;
  localparam int EV_ACQ    = 3;
  localparam int EV_BURST  = 4;
  localparam int EV_FULL   = 5;

  // latch vector positions
  localparam int LT_ACQ    = 0;
  localparam int LT_GEN    = 1;
  localparam int LT_BURST  = 2;
  localparam int LT_NEMPTY = 3;
  localparam int LT_FULL   = 4;

  // write word fields
  localparam int WB_GEN_EN  = 2;
  localparam int WB_ACQ_EN  = 3;
  localparam int WB_CLR_ACQ = 4;
  localparam int WB_CLR_GEN = 5;
  localparam int WB_CLR_FUL = 6;

  // read word fields
  localparam int RB_ACQ    = 0;
  localparam int RB_GEN    = 1;
  localparam int RB_BURST  = 2;
  localparam int RB_HALF   = 3;
  localparam int RB_NEMPTY = 4;
  localparam int RB_NE_LT  = 5;
  localparam int RB_FULL   = 6;
endpackage

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] hold_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        hold_o[g] <= 1'b0;
      else if (set_i[g]) hold_o[g] <= 1'b1;   // set beats clear
      else if (clr_i[g]) hold_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_latch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  output src_sel_e        sel_o,
  output logic            gen_en_o,
  output logic            acq_en_o,
  output logic            clr_acq_o,
  output logic            clr_gen_o,
  output logic            clr_full_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_o    <= SRC_NONE;
      gen_en_o <= 1'b0;
      acq_en_o <= 1'b0;
    end else if (wr_en_i) begin
      sel_o    <= src_sel_e'(wr_data_i[1:0]);
      gen_en_o <= wr_data_i[WB_GEN_EN];
      acq_en_o <= wr_data_i[WB_ACQ_EN];
    end
  end

  // strobes exist only during the write cycle
  assign clr_acq_o  = wr_en_i & wr_data_i[WB_CLR_ACQ];
  assign clr_gen_o  = wr_en_i & wr_data_i[WB_CLR_GEN];
  assign clr_full_o = wr_en_i & wr_data_i[WB_CLR_FUL];
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_not_empty_i,
  input  logic            fifo_half_full_i,
  input  logic            fifo_full_i,
  input  logic            scan_done_i,
  input  logic            acq_done_i,
  input  logic            burst_done_i,
  input  logic            burst_mode_i,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic [RD_W-1:0] rd_data_o,
  output logic            irq_o
);
  logic [NUM_EV-1:0] ev_lvl, ev_rise;
  logic [NUM_LT-1:0] lt_set, lt_clr, lt_q;
  src_sel_e          cfg_sel;
  logic              cfg_gen_en, cfg_acq_en;
  logic              clr_acq, clr_gen, clr_full;
  logic              gen_src_rise;

  always_comb begin
    ev_lvl            = '0;
    ev_lvl[EV_NEMPTY] = fifo_not_empty_i;
    ev_lvl[EV_HALF]   = fifo_half_full_i;
    ev_lvl[EV_SCAN]   = scan_done_i;
    ev_lvl[EV_ACQ]    = acq_done_i;
    ev_lvl[EV_BURST]  = burst_done_i;
    ev_lvl[EV_FULL]   = fifo_full_i;
  end

  irq_edge_bank #(.N(NUM_EV)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ev_lvl), .rise_o(ev_rise)
  );

  irq_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .sel_o(cfg_sel), .gen_en_o(cfg_gen_en), .acq_en_o(cfg_acq_en),
    .clr_acq_o(clr_acq), .clr_gen_o(clr_gen), .clr_full_o(clr_full)
  );

  always_comb begin
    unique case (cfg_sel)
      SRC_NEMPTY: gen_src_rise = ev_rise[EV_NEMPTY];
      SRC_HALF:   gen_src_rise = ev_rise[EV_HALF];
      SRC_SCAN:   gen_src_rise = ev_rise[EV_SCAN];
      default:    gen_src_rise = 1'b0;
    endcase
  end

  always_comb begin
    lt_set            = '0;
    lt_set[LT_ACQ]    = ev_rise[EV_ACQ];
    lt_set[LT_GEN]    = gen_src_rise & cfg_gen_en;
    lt_set[LT_BURST]  = ev_rise[EV_BURST] & burst_mode_i;
    lt_set[LT_NEMPTY] = ev_rise[EV_NEMPTY];
    lt_set[LT_FULL]   = ev_rise[EV_FULL];
    lt_clr            = '0;
    lt_clr[LT_ACQ]    = clr_acq;
    lt_clr[LT_BURST]  = clr_acq;
    lt_clr[LT_GEN]    = clr_gen;
    lt_clr[LT_NEMPTY] = clr_gen;
    lt_clr[LT_FULL]   = clr_full;
  end

  irq_sticky_bank #(.N(NUM_LT)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(lt_set), .clr_i(lt_clr), .hold_o(lt_q)
  );

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[RB_ACQ]    = lt_q[LT_ACQ];
    rd_data_o[RB_GEN]    = lt_q[LT_GEN];
    rd_data_o[RB_BURST]  = lt_q[LT_BURST];
    rd_data_o[RB_HALF]   = fifo_half_full_i;
    rd_data_o[RB_NEMPTY] = fifo_not_empty_i;
    rd_data_o[RB_NE_LT]  = lt_q[LT_NEMPTY];
    rd_data_o[RB_FULL]   = lt_q[LT_FULL];
  end

  assign irq_o = (lt_q[LT_GEN] & cfg_gen_en) | (lt_q[LT_ACQ] & cfg_acq_en);
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irq_latch_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic [WR_W-1:0] wr_data_i,
  input logic            fifo_full_i,
  input logic            acq_done_i,
  input logic            burst_mode_i,
  input logic [RD_W-1:0] rd_data_o,
  input logic            irq_o,
  input logic            cfg_gen_en
);
  p_irq_needs_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rd_data_o[RB_ACQ] | rd_data_o[RB_GEN]));

  p_full_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_full_i) |=> rd_data_o[RB_FULL]);

  p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[RB_FULL] && !(wr_en_i && wr_data_i[WB_CLR_FUL])) |=> rd_data_o[RB_FULL]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fifo_full_i) && wr_en_i && wr_data_i[WB_CLR_FUL]) |=> rd_data_o[RB_FULL]);

  p_burst_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_mode_i && !rd_data_o[RB_BURST]) |=> !rd_data_o[RB_BURST]);

  p_gen_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gen_en && !rd_data_o[RB_GEN]) |=> !rd_data_o[RB_GEN]);

  p_acq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[WB_CLR_ACQ] && !acq_done_i) |=> !rd_data_o[RB_ACQ]);

  p_gen_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[WB_CLR_GEN] && !cfg_gen_en) |=> !rd_data_o[RB_GEN]);
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .fifo_full_i(fifo_full_i), .acq_done_i(acq_done_i),
  .burst_mode_i(burst_mode_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
  .cfg_gen_en(cfg_gen_en)
);

// File: tb/irq_latch_ctrl_test.sv
`timescale 1ns/1ps
module irq_latch_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ne = 0, hf = 0, ff = 0, scan = 0, acq = 0, bd = 0, bmode = 0;
  logic wr_en = 0;
  logic [6:0] wr_data = '0;
  logic [6:0] rd;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_latch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fifo_not_empty_i(ne), .fifo_half_full_i(hf),
    .fifo_full_i(ff), .scan_done_i(scan), .acq_done_i(acq), .burst_done_i(bd),
    .burst_mode_i(bmode), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [6:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = '0;
  endtask

  task automatic clear_all();
    ne = 0; hf = 0; ff = 0; scan = 0; acq = 0; bd = 0; bmode = 0;
    step(); wr(7'h70);
  endtask

  task automatic t_reset();
    check("R1 status", {1'b0, rd}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_select();
    // R2 code 11: not-empty
    wr(7'b000_0111); ne = 1; step();
    check("R2 sel11 gen", {7'b0, rd[1]}, 8'h01);
    check("R11 irq gen", {7'b0, irq}, 8'h01);
    ne = 0; wr(7'b010_0111);
    check("R5 gen clear", {7'b0, rd[1]}, 8'h00);
    // R2 code 01: half-full, with scan edge ignored
    wr(7'b000_0101); scan = 1; step();
    check("R2 sel01 ignores scan", {7'b0, rd[1]}, 8'h00);
    scan = 0; hf = 1; step();
    check("R2 sel01 half", {7'b0, rd[1]}, 8'h01);
    hf = 0; wr(7'b010_0101);
    // R2 code 10: scan
    wr(7'b000_0110); scan = 1; step();
    check("R2 sel10 scan", {7'b0, rd[1]}, 8'h01);
    scan = 0; wr(7'b010_0110);
    // R2 code 00: nothing
    wr(7'b000_0100); ne = 1; hf = 1; scan = 1; step();
    check("R2 sel00 none", {7'b0, rd[1]}, 8'h00);
    check("R2 sel00 irq", {7'b0, irq}, 8'h00);
    clear_all();
  endtask

  task automatic t_disable();
    wr(7'b000_0011); ne = 1; step();
    check("R3 disabled gen", {7'b0, rd[1]}, 8'h00);
    check("R3 irq low", {7'b0, irq}, 8'h00);
    check("R10 ne latched", {7'b0, rd[5]}, 8'h01);
    check("R10 ne live", {7'b0, rd[4]}, 8'h01);
    clear_all();
    check("R5 ne latch cleared", {7'b0, rd[5]}, 8'h00);
  endtask

  task automatic t_acq();
    acq = 1; step();
    check("R4 acq latched", {7'b0, rd[0]}, 8'h01);
    check("R11 acq disabled irq", {7'b0, irq}, 8'h00);
    acq = 0; wr(7'b000_1000); step();
    check("R11 acq enabled irq", {7'b0, irq}, 8'h01);
    wr(7'b001_1000);
    check("R5 acq clear", {7'b0, rd[0]}, 8'h00);
    check("R11 irq drops", {7'b0, irq}, 8'h00);
    clear_all();
  endtask

  task automatic t_full();
    ff = 1; step(); ff = 0; step();
    check("R9 full sticky", {7'b0, rd[6]}, 8'h01);
    wr(7'b011_0000);   // R5: bit6 zero, others cleared
    check("R5 zero no effect", {7'b0, rd[6]}, 8'h01);
    wr(7'b100_0000);
    check("R5 full clear", {7'b0, rd[6]}, 8'h00);
    // R7: no rewrite needed
    ff = 1; step();
    check("R7 relatch after strobe", {7'b0, rd[6]}, 8'h01);
    ff = 0; wr(7'b100_0000);
    // R6: set wins
    ff = 1; wr(7'b100_0000);
    check("R6 set wins", {7'b0, rd[6]}, 8'h01);
    clear_all();
  endtask

  task automatic t_burst();
    bd = 1; step(); bd = 0; step();
    check("R8 burst gated", {7'b0, rd[2]}, 8'h00);
    bmode = 1; step(); bd = 1; step();
    check("R8 burst latched", {7'b0, rd[2]}, 8'h01);
    bd = 0; wr(7'b001_0000);
    check("R5 burst clear", {7'b0, rd[2]}, 8'h00);
    clear_all();
  endtask

  task automatic t_live_level();
    hf = 1; #1;
    check("R10 half live", {7'b0, rd[3]}, 8'h01);
    hf = 0; #1;
    check("R10 half live low", {7'b0, rd[3]}, 8'h00);
    wr(7'b000_0111); ne = 1; step();
    wr(7'b010_0111); step(); step();
    check("R12 level no relatch", {7'b0, rd[1]}, 8'h00);
    check("R12 ne latch stays clear", {7'b0, rd[5]}, 8'h00);
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    step();
    t_reset();
    t_select();
    t_disable();
    t_acq();
    t_full();
    t_burst();
    t_live_level();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule